// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block sits on the device side of a synchronous DRAM, between the registered command decoder and the storage array. When a READ or WRITE is accepted, it records the bank and the starting column. It then produces one column address per beat, in sequential or interleaved order. The address wraps inside the block of columns that is aligned to the burst length. The engine also drives the array read and write enables. On reads, a drive-enable for the data pins follows the array reads after the programmed CAS latency of 2 or 3 cycles.

A clock-enable input freezes the engine. A rising edge that samples it low turns the next rising edge into a suspended edge. On a suspended edge no state moves: the beat counter, the column, the latency pipeline and the data-pin drive all hold, and any command or write data present is ignored. A mode bit makes every WRITE a single beat while READs keep the programmed length. A new command accepted in the middle of a burst cuts the old burst short and starts the new one from its own column.

Top module: `sdram_col_burst`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and after it, before any command, arr_rd, arr_wr, dq_oe and burst_done are all 0.
- R2: A READ (cmd_rd=1, which wins over cmd_wr) or a WRITE (cmd_wr=1) is accepted on an active edge. In the next cycle arr_bank equals the bank given, arr_col equals the starting column, beat is 0, and arr_rd or arr_wr is 1.
- R3: bl_code 0,1,2,3 selects a burst of 1,2,4,8 beats. Each active edge advances one beat. After the active edge that ends the final beat, burst_done is 1 for exactly one cycle and arr_rd/arr_wr are 0, unless a new command was accepted on that edge. arr_rd and arr_wr are never both 1.
- R4: With interleave=0 the column for beat b is the start column with its low log2(L) bits replaced by (start + b) mod L, where L is the burst length. The upper bits are unchanged.
- R5: With interleave=1 the low log2(L) bits are (start XOR b). The upper bits are unchanged.
- R6: An edge is suspended when the edge before it sampled cke low. On a suspended edge, beat, arr_col and the read-latency pipeline hold their values. arr_rd/arr_wr are 0 during any cycle that ends in a suspended edge. Normal advance resumes on the first edge after cke is sampled high.
- R7: A READ or WRITE presented on a suspended edge is ignored: it neither starts, ends nor alters a burst.
- R8: dq_oe is the array read enable delayed by (CL-1) active edges. CL is 2 when cas3=0 and 3 when cas3=1. Suspended edges stretch this delay, and dq_oe holds its value through them.
- R9: When wr_single=1 at the WRITE, the write is exactly one beat at the start column. READs accepted with wr_single=1 still use the full programmed length and order.
- R10: A command accepted on an active edge during a burst ends that burst at once. No burst_done is given for it, and the new burst starts from its own column and bank in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; a low sample suspends the next edge |
| cmd_rd | input | 1 | Decoded READ command |
| cmd_wr | input | 1 | Decoded WRITE command |
| bank | input | BANK_W | Bank of the command |
| col | input | COL_W | Starting column of the command |
| bl_code | input | 2 | Burst length code (1,2,4,8) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| cas3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| wr_single | input | 1 | 1 = writes are single beat |
| arr_bank | output | BANK_W | Bank of the current access |
| arr_col | output | COL_W | Column of the current beat |
| arr_rd | output | 1 | Array read enable for this cycle |
| arr_wr | output | 1 | Array write enable for this cycle |
| dq_oe | output | 1 | Data pin drive enable for read data |
| beat | output | BEAT_W | Index of the current beat |
| burst_done | output | 1 | One-cycle pulse after a burst completes |

## Verification
An accepted command shows up on arr_col, arr_bank, beat and the enables in the cycle right after its edge. burst_done appears one cycle after the active edge that ends the last beat. dq_oe rises CL-1 active edges after the READ edge, and each suspended edge pushes it back by one more cycle. The bench drives inputs and samples outputs on the falling edge. It advances its own model of these rules on every rising edge, so each comparison falls in the cycle where the result is due. Directed sequences give exact column orders and suspend positions, and they check them at fixed negedge counts after the command.

// File: rtl/sdram_col_burst.sv
module sdram_col_burst #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int MAX_BL = 8,
  localparam int BEAT_W = $clog2(MAX_BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        bl_code,
  input  logic              interleave,
  input  logic              cas3,
  input  logic              wr_single,
  output logic [BANK_W-1:0] arr_bank,
  output logic [COL_W-1:0]  arr_col,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic              dq_oe,
  output logic [BEAT_W-1:0] beat,
  output logic              burst_done
);

  logic              cke_q, busy_q, wr_q, il_q, done_q;
  logic [BEAT_W-1:0] beat_q, last_q;
  logic [COL_W-1:0]  start_q;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        rd_pipe;

  wire act     = cke_q;
  wire new_cmd = act && (cmd_rd || cmd_wr);
  wire is_wr   = cmd_wr && !cmd_rd;
  wire at_last = beat_q == last_q;

  wire [BEAT_W-1:0] new_last = (is_wr && wr_single) ? '0
                             : BEAT_W'((32'd1 << bl_code) - 32'd1);

  wire [COL_W-1:0] mask     = COL_W'(last_q);
  wire [COL_W-1:0] beat_ext = COL_W'(beat_q);
  wire [COL_W-1:0] low      = il_q ? (start_q ^ beat_ext) : (start_q + beat_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      il_q    <= 1'b0;
      done_q  <= 1'b0;
      beat_q  <= '0;
      last_q  <= '0;
      start_q <= '0;
      bank_q  <= '0;
      rd_pipe <= '0;
    end else begin
      cke_q  <= cke;
      done_q <= act && busy_q && at_last && !new_cmd;
      if (act) begin
        rd_pipe <= {rd_pipe[0], busy_q && !wr_q};
        if (new_cmd) begin
          busy_q  <= 1'b1;
          wr_q    <= is_wr;
          il_q    <= interleave;
          start_q <= col;
          bank_q  <= bank;
          beat_q  <= '0;
          last_q  <= new_last;
        end else if (busy_q) begin
          if (at_last) busy_q <= 1'b0;
          else         beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign arr_bank   = bank_q;
  assign arr_col    = (start_q & ~mask) | (low & mask);
  assign arr_rd     = busy_q && !wr_q && cke_q;
  assign arr_wr     = busy_q && wr_q && cke_q;
  assign dq_oe      = cas3 ? rd_pipe[1] : rd_pipe[0];
  assign beat       = beat_q;
  assign burst_done = done_q;

  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> $stable(beat_q) && $stable(arr_col));
  a_r8_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> $stable(rd_pipe));
  a_r7_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && !busy_q) |=> !arr_rd && !arr_wr);
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd && arr_wr));
  a_r3_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> beat_q <= last_q);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cmd_wr && !cmd_rd && wr_single) |=> last_q == '0);

endmodule

// File: tb/sim_sdram_col_burst.sv
module sim_sdram_col_burst;
  localparam int COL_W = 9, BANK_W = 2;

  logic clk = 0, rst_n = 0, cke = 1, cmd_rd = 0, cmd_wr = 0;
  logic [BANK_W-1:0] bank = 0;
  logic [COL_W-1:0]  col = 0;
  logic [1:0] bl_code = 0;
  logic interleave = 0, cas3 = 0, wr_single = 0;
  logic [BANK_W-1:0] arr_bank;
  logic [COL_W-1:0]  arr_col;
  logic arr_rd, arr_wr, dq_oe, burst_done;
  logic [2:0] beat;

  int checks = 0, fails = 0;
  bit finished = 0, cmp_on = 0;

  always #5 clk = ~clk;

  sdram_col_burst #(.COL_W(COL_W), .BANK_W(BANK_W), .MAX_BL(8)) u0 (
    .clk, .rst_n, .cke, .cmd_rd, .cmd_wr, .bank, .col, .bl_code, .interleave,
    .cas3, .wr_single, .arr_bank, .arr_col, .arr_rd, .arr_wr, .dq_oe, .beat,
    .burst_done);

  function automatic int exp_col(int start, int b, int len, bit il);
    int base = start - (start % len);
    int off  = start % len;
    return il ? base + (off ^ b) : base + ((off + b) % len);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  bit m_ckeq = 1, m_busy = 0, m_wr = 0, m_il = 0, m_done = 0, m_p0 = 0, m_p1 = 0;
  int m_beat = 0, m_len = 1, m_start = 0, m_bank = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ckeq = 1; m_busy = 0; m_wr = 0; m_done = 0; m_p0 = 0; m_p1 = 0; m_beat = 0;
    end else begin
      m_done = 0;
      if (m_ckeq) begin
        m_p1 = m_p0;
        m_p0 = m_busy && !m_wr;
        if (cmd_rd || cmd_wr) begin
          m_busy = 1; m_wr = !cmd_rd; m_il = interleave; m_start = col;
          m_bank = bank; m_beat = 0;
          m_len = (m_wr && wr_single) ? 1 : (1 << bl_code);
        end else if (m_busy) begin
          if (m_beat == m_len - 1) begin m_busy = 0; m_done = 1; end
          else m_beat++;
        end
      end
      m_ckeq = cke;
    end
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk(arr_rd == (m_busy && !m_wr && m_ckeq), "R3 arr_rd", arr_rd, m_busy && !m_wr && m_ckeq);
    chk(arr_wr == (m_busy && m_wr && m_ckeq), "R3 arr_wr", arr_wr, m_busy && m_wr && m_ckeq);
    chk(burst_done == m_done, "R3 burst_done", burst_done, m_done);
    chk(dq_oe == (cas3 ? m_p1 : m_p0), "R8 dq_oe", dq_oe, cas3 ? m_p1 : m_p0);
    if (m_busy) begin
      chk(int'(arr_col) == exp_col(m_start, m_beat, m_len, m_il), m_il ? "R5 arr_col" : "R4 arr_col",
          arr_col, exp_col(m_start, m_beat, m_len, m_il));
      chk(int'(beat) == m_beat, "R6 beat", beat, m_beat);
      chk(int'(arr_bank) == m_bank, "R2 arr_bank", arr_bank, m_bank);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input bit rd, input int bk, input int c, input int blc, input bit il);
    cmd_rd = rd; cmd_wr = !rd; bank = BANK_W'(bk); col = COL_W'(c);
    bl_code = 2'(blc); interleave = il;
    tick();
    cmd_rd = 0; cmd_wr = 0;
  endtask

  task automatic do_reset(input bit c3);
    rst_n = 0; cke = 1; cmd_rd = 0; cmd_wr = 0; cas3 = c3;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(!arr_rd && !arr_wr && !dq_oe && !burst_done, "R1 reset outputs", {arr_rd, arr_wr, dq_oe, burst_done}, 0);
    do_reset(0);
    chk(!arr_rd && !arr_wr && !dq_oe && !burst_done, "R1 after reset", {arr_rd, arr_wr, dq_oe, burst_done}, 0);
    cmp_on = 1;

    // R2, R4, R8: read 2 beats from column 5, bank 2, CL2
    issue(1, 2, 5, 1, 0);
    chk(arr_rd && arr_col == 5 && arr_bank == 2 && beat == 0, "R2 start", arr_col, 5);
    tick();
    chk(arr_col == 4, "R4 wrap", arr_col, 4);
    chk(dq_oe, "R8 CL2 first beat", dq_oe, 1);
    tick();
    chk(burst_done && !arr_rd, "R3 done pulse", burst_done, 1);
    tick();
    chk(!burst_done, "R3 done one cycle", burst_done, 0);

    // R5: interleaved 8 beats from 6
    issue(1, 1, 6, 3, 1);
    for (int b = 0; b < 8; b++) begin
      chk(arr_col == COL_W'(6 ^ b), "R5 interleave order", arr_col, 6 ^ b);
      tick();
    end

    // R6: suspend in read burst
    issue(1, 0, 32, 2, 0);
    cke = 0; tick();
    chk(arr_col == 33 && !arr_rd, "R6 beat then freeze", arr_col, 33);
    cke = 1; tick();
    chk(arr_col == 33 && arr_rd, "R6 held on suspended edge", arr_col, 33);
    tick();
    chk(arr_col == 34, "R6 resume", arr_col, 34);
    repeat (4) tick();

    // R7: command on suspended edge ignored
    cke = 0; tick();
    cke = 1; issue(0, 3, 100, 2, 0);
    chk(!arr_wr && !arr_rd, "R7 cmd ignored", arr_wr, 0);
    tick();
    chk(!arr_wr && !burst_done, "R7 still idle", arr_wr, 0);

    // R9: single-beat write, full-length read
    wr_single = 1;
    issue(0, 1, 77, 3, 0);
    chk(arr_wr && arr_col == 77, "R9 single write beat", arr_col, 77);
    tick();
    chk(!arr_wr && burst_done, "R9 write ends after one", arr_wr, 0);
    issue(1, 1, 77, 3, 0);
    begin
      int n = 0;
      for (int k = 0; k < 10; k++) begin if (arr_rd) n++; tick(); end
      chk(n == 8, "R9 read keeps length", n, 8);
    end
    wr_single = 0;

    // R10: truncate read with write
    issue(1, 0, 16, 3, 0);
    tick();
    issue(0, 2, 40, 2, 0);
    chk(arr_wr && arr_col == 40 && arr_bank == 2 && !burst_done, "R10 truncate", arr_col, 40);
    repeat (6) tick();

    // random phase, both latencies
    for (int seg = 0; seg < 4; seg++) begin
      do_reset(seg[0]);
      for (int i = 0; i < 1500; i++) begin
        int r = $urandom_range(0, 99);
        cke = ($urandom_range(0, 99) < 78);
        cmd_rd = (r < 10); cmd_wr = (r >= 10 && r < 18) || (r == 5);
        bank = BANK_W'($urandom); col = COL_W'($urandom);
        bl_code = 2'($urandom); interleave = 1'($urandom);
        wr_single = ($urandom_range(0, 3) == 0);
        tick();
      end
      cmd_rd = 0; cmd_wr = 0; cke = 1;
      repeat (12) tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule